// File: doc/BRIEF.md
# Cycle-Stealing Two-Channel DMA Controller

This block moves data between memory locations without running code on the processor. It has two channels. Each one holds a source address, a destination address, a working address that advances after every move, a 16-bit count of moves still to make, and the value that count is refilled from. A channel gets a request from a software register write or from its peripheral interrupt line. The block then asks the processor for the shared memory bus. When the processor grants the bus, the block performs one read followed by one write, and then gives the bus back. The processor loses the bus for exactly one transfer per request. There is no burst mode.

A single transfer moves either one byte or one 16-bit word, chosen per channel. A per-channel direction bit selects which side walks through memory: either the source advances while the destination stays fixed, or the destination advances while the source stays fixed. Each channel keeps one pending flag, so requests that arrive before the transfer starts fold into a single transfer. When the count runs out, the channel switches itself off, pulses its done output and refills the count.

Software setup goes through a write-only port. `reg_ch` picks the channel, `reg_field` picks the register, and `reg_wdata` carries the value. The memory bus is synchronous: read data returns in the cycle after the read strobe.

Top module: `dma2_steal`

## Requirements
- R1: After reset, `bus_req`, `mem_en`, `mem_we` and `done` are all 0.
- R2: A request reaching a disabled channel is dropped; it does not start a transfer even if the channel is enabled later. The control field is code 3, and its bit 0 is the enable.
- R3: `mem_en` is only high while `bus_req` is high. `bus_req` drops in the cycle after the write strobe, so each grant covers one transfer.
- R4: A transfer is a read strobe (`mem_we`=0) at the read address, an idle cycle, then a write strobe (`mem_we`=1) at the write address carrying the data read.
- R5: Control bit 1 selects word size. A word transfer sets `mem_size`=1 and copies all 16 bits. A byte transfer sets `mem_size`=0 and copies the low byte, with the upper byte written as zero.
- R6: After each transfer, the working address grows by 2 for words and 1 for bytes. Control bit 2 = 0 means reads use the working address (loaded from the source, field 0) and writes go to the destination (field 1). Bit 2 = 1 swaps the roles: reads come from the source and writes use the working address, loaded from the destination. The working address reloads whenever the control field is written with enable set.
- R7: When both channels are pending at the moment the bus is granted, channel 0 is served first.
- R8: Several requests that arrive on one channel before its transfer starts produce exactly one transfer.
- R9: Writing the reload field (code 2) also loads the count. The transfer that brings the count to zero clears the enable, pulses that channel's `done` for one cycle and refills the count from the reload value. A reload value of 0 means 65536 transfers.
- R10: A request comes either from a write to field 4 with bit 0 set, or from a cycle with the channel's `irq_req` line high.
- R11: `bus_req` only rises while `bus_gnt` is low. No memory strobe appears until `bus_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 1 | Channel selected for the write |
| reg_field | input | 3 | Field code: 0 source, 1 destination, 2 reload, 3 control, 4 software request |
| reg_wdata | input | 20 | Write data |
| irq_req | input | 2 | Peripheral request line, one per channel |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted by the processor |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = word, 0 = byte |
| mem_addr | output | 20 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read strobe |
| done | output | 2 | One-cycle pulse when a channel's count runs out |

## Verification
The bench targets the following cases:

- **Request merging.** It holds the grant off while requests pile up on one channel. A design that queued them would issue extra transfers that the expected-access queue does not contain.
- **Stale grant.** It lags the grant release by a cycle. A design that re-requested while the old grant was still high would start a transfer without a real grant.
- **Arbitration.** It fires both channels in the same cycle to check that channel 0 goes first.
- **Count expiry and refill.** It checks that a request after expiry is dropped and that re-enabling gives exactly the reload count again. An off-by-one counter, or a channel that stays enabled, shows up as a missing or surplus transfer.
- **Byte mode with destination walking.** It catches a wrong step size, a wrong byte lane or swapped address roles.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_RD,
    ST_LAT,
    ST_WR
  } eng_st_t;

  localparam logic [2:0] FLD_SRC    = 3'd0;
  localparam logic [2:0] FLD_DST    = 3'd1;
  localparam logic [2:0] FLD_RELOAD = 3'd2;
  localparam logic [2:0] FLD_CTRL   = 3'd3;
  localparam logic [2:0] FLD_SWREQ  = 3'd4;

  localparam int CTL_EN   = 0;
  localparam int CTL_WORD = 1;
  localparam int CTL_DIR  = 2;
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          irq,
  input  logic          start,
  input  logic          finish,
  output logic          active,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic          word,
  output logic          done_o
);
  logic [AW-1:0] src_q, dst_q, fwd_q;
  logic [CW-1:0] cnt_q, reload_q;
  logic          en_q, word_q, dir_q, pend_q, done_q;
  logic [AW-1:0] step;
  logic          sw_hit, last_xfer;

  assign step      = word_q ? AW'(2) : AW'(1);
  assign sw_hit    = wr_en && (wr_field == FLD_SWREQ) && wr_data[0];
  assign last_xfer = finish && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      dst_q    <= '0;
      fwd_q    <= '0;
      cnt_q    <= '0;
      reload_q <= '0;
      en_q     <= 1'b0;
      word_q   <= 1'b0;
      dir_q    <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) pend_q <= 1'b0;
      if (finish) begin
        fwd_q <= fwd_q + step;
        if (last_xfer) begin
          en_q   <= 1'b0;
          cnt_q  <= reload_q;
          done_q <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
      if ((irq || sw_hit) && en_q && !last_xfer) pend_q <= 1'b1;
      if (wr_en) begin
        case (wr_field)
          FLD_SRC: src_q <= wr_data;
          FLD_DST: dst_q <= wr_data;
          FLD_RELOAD: begin
            reload_q <= wr_data[CW-1:0];
            cnt_q    <= wr_data[CW-1:0];
          end
          FLD_CTRL: begin
            en_q   <= wr_data[CTL_EN];
            word_q <= wr_data[CTL_WORD];
            dir_q  <= wr_data[CTL_DIR];
            if (wr_data[CTL_EN]) fwd_q <= wr_data[CTL_DIR] ? dst_q : src_q;
            else pend_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign active  = pend_q;
  assign rd_addr = dir_q ? src_q : fwd_q;
  assign wr_addr = dir_q ? fwd_q : dst_q;
  assign word    = word_q;
  assign done_o  = done_q;

  assert_pend_needs_en_R2: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> en_q);

  assert_expiry_refill_R9: assert property (@(posedge clk) disable iff (rst)
    (done_q && !$past(wr_en)) |-> (!en_q && cnt_q == reload_q));

  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (finish && !wr_en) |=> (fwd_q == $past(fwd_q) + $past(step)));
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
  parameter int NCH = 2,
  parameter int CHW = 1
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] grant,
  output logic [CHW-1:0] idx
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
  import dma2_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CHW = 1,
  parameter int AW  = 20,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    pend,
  input  logic [NCH-1:0]    win_oh,
  input  logic [CHW-1:0]    win_idx,
  input  logic [NCH*AW-1:0] rd_addr_flat,
  input  logic [NCH*AW-1:0] wr_addr_flat,
  input  logic [NCH-1:0]    word_vec,
  input  logic              bus_gnt,
  input  logic [DW-1:0]     mem_rdata,
  output logic              bus_req,
  output logic              mem_en,
  output logic              mem_we,
  output logic              mem_size,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [NCH-1:0]    start,
  output logic [NCH-1:0]    finish
);
  eng_st_t        st;
  logic [CHW-1:0] cur;
  logic [NCH-1:0] cur_oh;

  assign start  = (st == ST_HOLD && bus_gnt) ? win_oh : '0;
  assign finish = (st == ST_WR) ? cur_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur       <= '0;
      cur_oh    <= '0;
      bus_req   <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (|pend && !bus_gnt) begin
            bus_req <= 1'b1;
            st      <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!(|pend)) begin
            bus_req <= 1'b0;
            st      <= ST_IDLE;
          end else if (bus_gnt) begin
            cur      <= win_idx;
            cur_oh   <= win_oh;
            mem_en   <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= rd_addr_flat[win_idx*AW +: AW];
            mem_size <= word_vec[win_idx];
            st       <= ST_RD;
          end
        end
        ST_RD: begin
          mem_en <= 1'b0;
          st     <= ST_LAT;
        end
        ST_LAT: begin
          mem_wdata <= mem_size ? mem_rdata : {{(DW-8){1'b0}}, mem_rdata[7:0]};
          mem_en    <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= wr_addr_flat[cur*AW +: AW];
          st        <= ST_WR;
        end
        ST_WR: begin
          mem_en  <= 1'b0;
          mem_we  <= 1'b0;
          bus_req <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_strobe_under_req_R3: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> bus_req);

  assert_release_after_write_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |=> !bus_req);

  assert_req_rise_clean_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !$past(bus_gnt));

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> !mem_en ##1 (mem_en && mem_we));

  assert_single_start_R7: assert property (@(posedge clk) disable iff (rst)
    (|start) |-> $onehot(start));

  assert_low_channel_wins_R7: assert property (@(posedge clk) disable iff (rst)
    ((|start) && pend[0]) |-> start[0]);
endmodule

// File: rtl/dma2_steal.sv
module dma2_steal #(
  parameter int NCH = 2,
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [CHW-1:0] reg_ch,
  input  logic [2:0]     reg_field,
  input  logic [AW-1:0]  reg_wdata,
  input  logic [NCH-1:0] irq_req,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           mem_en,
  output logic           mem_we,
  output logic           mem_size,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [NCH-1:0] done
);
  logic [NCH-1:0]    pend, win_oh, word_vec, start, finish;
  logic [CHW-1:0]    win_idx;
  logic [NCH*AW-1:0] rd_flat, wr_flat;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma2_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (reg_we && (reg_ch == CHW'(g))),
      .wr_field (reg_field),
      .wr_data  (reg_wdata),
      .irq      (irq_req[g]),
      .start    (start[g]),
      .finish   (finish[g]),
      .active   (pend[g]),
      .rd_addr  (rd_flat[g*AW +: AW]),
      .wr_addr  (wr_flat[g*AW +: AW]),
      .word     (word_vec[g]),
      .done_o   (done[g])
    );
  end

  dma2_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .req   (pend),
    .grant (win_oh),
    .idx   (win_idx)
  );

  dma2_engine #(.NCH(NCH), .CHW(CHW), .AW(AW), .DW(DW)) u_engine (
    .clk          (clk),
    .rst          (rst),
    .pend         (pend),
    .win_oh       (win_oh),
    .win_idx      (win_idx),
    .rd_addr_flat (rd_flat),
    .wr_addr_flat (wr_flat),
    .word_vec     (word_vec),
    .bus_gnt      (bus_gnt),
    .mem_rdata    (mem_rdata),
    .bus_req      (bus_req),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .mem_size     (mem_size),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .start        (start),
    .finish       (finish)
  );
endmodule

// File: tb/dma2_steal_bench.sv
`timescale 1ns/1ps
module dma2_steal_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [0:0]  reg_ch = '0;
  logic [2:0]  reg_field = '0;
  logic [19:0] reg_wdata = '0;
  logic [1:0]  irq_req = '0;
  logic        bus_req, bus_gnt, mem_en, mem_we, mem_size;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0]  done;
  logic        gnt_hold = 1'b1;

  int checks = 0;
  int errs   = 0;
  int done_cnt0 = 0;
  int done_cnt1 = 0;

  logic [19:0] q_addr[$];
  bit          q_we[$];
  logic [15:0] q_data[$];
  bit          q_size[$];

  always #2.5 clk = ~clk;

  dma2_steal u_dma2_steal (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_ch(reg_ch), .reg_field(reg_field),
    .reg_wdata(reg_wdata), .irq_req(irq_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
  );

  function automatic logic [15:0] pat(input logic [19:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // processor side: grant follows request one cycle later
  always @(posedge clk) begin
    if (rst) bus_gnt <= 1'b0;
    else     bus_gnt <= bus_req && !gnt_hold;
  end

  // memory side: registered read
  always @(posedge clk) begin
    if (mem_en && !mem_we) mem_rdata <= pat(mem_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_xfer(input logic [19:0] ra, input logic [19:0] wa, input bit word);
    logic [15:0] d;
    d = pat(ra);
    if (!word) d = {8'h00, d[7:0]};
    q_addr.push_back(ra); q_we.push_back(1'b0); q_data.push_back(16'h0); q_size.push_back(word);
    q_addr.push_back(wa); q_we.push_back(1'b1); q_data.push_back(d);     q_size.push_back(word);
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (done[0]) done_cnt0++;
      if (done[1]) done_cnt1++;
      if (mem_en) begin
        chk(bus_req && bus_gnt, "R11 strobe without grant", {30'd0, bus_req, bus_gnt}, 32'h3);
        if (q_addr.size() == 0) begin
          chk(1'b0, "R8 unexpected access", {12'd0, mem_addr}, 32'h0);
        end else begin
          chk(mem_addr == q_addr[0], "R6 address", {12'd0, mem_addr}, {12'd0, q_addr[0]});
          chk(mem_we == q_we[0], "R4 access order", {31'd0, mem_we}, {31'd0, q_we[0]});
          chk(mem_size == q_size[0], "R5 size", {31'd0, mem_size}, {31'd0, q_size[0]});
          if (q_we[0]) chk(mem_wdata == q_data[0], "R5 data", {16'd0, mem_wdata}, {16'd0, q_data[0]});
          void'(q_addr.pop_front()); void'(q_we.pop_front());
          void'(q_data.pop_front()); void'(q_size.pop_front());
        end
      end
    end
  end

  task automatic reg_wr(input bit ch, input logic [2:0] f, input logic [19:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = ch; reg_field = f; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_irq(input logic [1:0] v, input int n);
    @(negedge clk);
    irq_req = v;
    repeat (n) @(negedge clk);
    irq_req = 2'b00;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    gnt_hold = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!bus_req && !mem_en && !mem_we && done == 2'b00, "R1 reset outputs",
        {28'd0, bus_req, mem_en, done}, 32'h0);

    // channel 0: word, source walks, count 3
    reg_wr(1'b0, 3'd0, 20'h10000);
    reg_wr(1'b0, 3'd1, 20'h20000);
    reg_wr(1'b0, 3'd2, 20'd3);
    reg_wr(1'b0, 3'd3, 20'b011);

    // R10 software request
    expect_xfer(20'h10000, 20'h20000, 1'b1);
    reg_wr(1'b0, 3'd4, 20'h1);
    settle();
    chk(q_addr.size() == 0, "R10 software request served", q_addr.size(), 0);

    // R10 interrupt line, R6 word step
    expect_xfer(20'h10002, 20'h20000, 1'b1);
    pulse_irq(2'b01, 1);
    settle();
    chk(q_addr.size() == 0, "R10 interrupt request served", q_addr.size(), 0);
    chk(done_cnt0 == 0, "R9 no early done", done_cnt0, 0);

    // R8 merge while grant withheld, R11 no strobe before grant
    gnt_hold = 1'b1;
    expect_xfer(20'h10004, 20'h20000, 1'b1);
    pulse_irq(2'b01, 3);
    reg_wr(1'b0, 3'd4, 20'h1);
    repeat (4) @(negedge clk);
    chk(bus_req == 1'b1, "R11 request waits for grant", bus_req, 1);
    chk(mem_en == 1'b0, "R11 no strobe before grant", mem_en, 0);
    gnt_hold = 1'b0;
    settle();
    chk(q_addr.size() == 0, "R8 merged to one transfer", q_addr.size(), 0);
    chk(done_cnt0 == 1, "R9 done after count", done_cnt0, 1);

    // R9 channel disabled after expiry
    reg_wr(1'b0, 3'd4, 20'h1);
    settle();
    chk(bus_req == 1'b0, "R9 request after expiry dropped", bus_req, 0);

    // R2 request to disabled channel 1, then enable
    pulse_irq(2'b10, 2);
    reg_wr(1'b1, 3'd0, 20'h300F0);
    reg_wr(1'b1, 3'd1, 20'h40000);
    reg_wr(1'b1, 3'd2, 20'd0);
    reg_wr(1'b1, 3'd3, 20'b101);
    settle();
    chk(bus_req == 1'b0 && q_addr.size() == 0, "R2 disabled request not kept", bus_req, 0);

    // R7 both pending: channel 0 first
    reg_wr(1'b0, 3'd3, 20'b011);
    gnt_hold = 1'b1;
    expect_xfer(20'h10000, 20'h20000, 1'b1);
    expect_xfer(20'h300F0, 20'h40000, 1'b0);
    pulse_irq(2'b11, 1);
    repeat (3) @(negedge clk);
    gnt_hold = 1'b0;
    repeat (30) @(negedge clk);
    chk(q_addr.size() == 0, "R7 both served in order", q_addr.size(), 0);

    // R5/R6 byte step on walking destination
    expect_xfer(20'h300F0, 20'h40001, 1'b0);
    pulse_irq(2'b10, 1);
    settle();
    chk(q_addr.size() == 0, "R6 byte destination step", q_addr.size(), 0);

    // R9 refill: two more on channel 0 finish the reloaded count
    expect_xfer(20'h10002, 20'h20000, 1'b1);
    reg_wr(1'b0, 3'd4, 20'h1);
    settle();
    expect_xfer(20'h10004, 20'h20000, 1'b1);
    reg_wr(1'b0, 3'd4, 20'h1);
    settle();
    chk(done_cnt0 == 2, "R9 count refilled", done_cnt0, 2);
    chk(done_cnt1 == 0, "R9 zero reload means long count", done_cnt1, 0);
    chk(q_addr.size() == 0 && !bus_req, "R3 bus released", {31'd0, bus_req}, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule